// File: doc/BRIEF.md
# I2C Address-Match Wakeup Controller

This block is the target-side front end of an I2C port that stays alive while the system's fast kernel clock is switched off. When it sees a START condition on the bus, it raises a clock request. It then holds SCL low until the clock source reports that it is running. Once the clock is ready it releases SCL and shifts in the address byte.

When the address matches, the block acknowledges the byte and raises a wakeup output. After the ninth clock it keeps SCL low while the system wakes. Software lets the transfer go on by clearing the matched flag. When the address does not match, the block leaves SDA alone, withdraws the clock request and issues no wakeup, so the system can stay asleep.

SCL and SDA both pass through a two-flop synchronizer and a short glitch filter before any edge detection. The general-call address takes part in matching only when it is enabled.

Top module: `i2c_wake_ctrl`

## Requirements
- R1: After reset, scl_oe, sda_oe, clk_req and wake_o are all 0.
- R2: A START (SDA falling while SCL is high) sets clk_req to 1 and drives scl_oe to 1.
- R3: While clk_req is 1 and clk_rdy is 0 after a START, scl_oe stays 1. No address bit is taken until clk_rdy is 1, after which scl_oe is released.
- R4: The address byte is shifted in MSB first on SCL rising edges. Bits 7..1 of the byte are the 7-bit address and bit 0 is the read/write bit, which does not affect matching.
- R5: On a match, the block drives SDA low (sda_oe = 1) from the falling SCL edge after the eighth bit until the falling edge of the ninth clock, and sets wake_o to 1.
- R6: After a match, scl_oe is 1 from the ninth falling SCL edge until flag_clr is pulsed. The pulse releases SCL and clears wake_o, and clk_req stays 1 until a STOP.
- R7: On a mismatch, sda_oe stays 0, wake_o stays 0 and clk_req returns to 0.
- R8: Address 0 matches only when gc_en is 1. A nonzero address matches only when it equals own_addr.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle with clk_req at 0.
- R10: A pulse on SDA or SCL that is shorter than the filter length is ignored. A one-cycle SDA low pulse while the bus is idle does not raise clk_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| clk_req | output | 1 | Fast clock request |
| clk_rdy | input | 1 | Fast clock running |
| own_addr | input | 7 | Own 7-bit target address |
| gc_en | input | 1 | Lets address 0 match |
| wake_o | output | 1 | Address-matched wakeup flag |
| flag_clr | input | 1 | Software clear of the matched flag |

## Verification
Some properties are checked by assertions on every cycle:
- SCL is never held while the clock request is low.
- SCL and SDA are never pulled at the same time.
- An acknowledge is only driven while the clock request is high.
- The wakeup flag only rises while SCL is free.
- A clear of the matched flag while the clock is ready releases SCL on the next cycle.

Other behaviour needs whole bus transactions, so only the bench scenarios can show it:
- which addresses match, including every 7-bit address against one own address and the general call with its enable on and off;
- the length of the stretch while the clock starts;
- the withdrawal of the clock request on a mismatch and on STOP;
- rejection of a short glitch.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_CLK,
        ST_RX_ADDR,
        ST_ACK,
        ST_HOLD_WAKE,
        ST_RELEASE,
        ST_DONE
    } wk_state_e;

    localparam int ADDR_BITS  = 7;
    localparam int FRAME_BITS = ADDR_BITS + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        wk_state_e              st;
        logic [FRAME_BITS-1:0]  sh;
        logic [CNT_W-1:0]       cnt;
        logic                   ack_drv;
        logic                   req;
        logic                   flag;
    } wk_regs_t;

endpackage

// File: rtl/i2c_wake_filt.sv
module i2c_wake_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_d, sync_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          out_d, out_q;

    always_comb begin
        sync_d = {sync_q[0], raw};
        cnt_d  = '0;
        out_d  = out_q;
        if (sync_q[1] != out_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                out_d = sync_q[1];
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign clean = out_q;
endmodule

// File: rtl/i2c_wake_cond.sv
module i2c_wake_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start,
    output logic stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl;
        sda_d = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign start    = scl & scl_q & sda_q & ~sda;
    assign stop     = scl & scl_q & ~sda_q & sda;
    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
endmodule

// File: rtl/i2c_wake_ctrl.sv
module i2c_wake_ctrl #(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       clk_req,
    input  logic       clk_rdy,
    input  logic [6:0] own_addr,
    input  logic       gc_en,
    output logic       wake_o,
    input  logic       flag_clr
);
    import i2c_wake_pkg::*;

    logic [1:0] line_raw;
    logic [1:0] line_clean;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_wake_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (line_raw[g]),
            .clean (line_clean[g])
        );
    end

    logic start, stop, scl_rise, scl_fall;

    i2c_wake_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (line_clean[0]),
        .sda      (line_clean[1]),
        .start    (start),
        .stop     (stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    wk_regs_t              r_d, r_q;
    logic [FRAME_BITS-1:0] sh_nx;
    logic [ADDR_BITS-1:0]  rx_addr;
    logic                  hit;

    always_comb begin
        sh_nx   = {r_q.sh[FRAME_BITS-2:0], line_clean[1]};
        rx_addr = sh_nx[FRAME_BITS-1:1];
        hit     = (rx_addr == '0) ? gc_en : (rx_addr == own_addr);
    end

    always_comb begin
        r_d = r_q;
        if (flag_clr) begin
            r_d.flag = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: ;
            ST_WAIT_CLK: begin
                if (clk_rdy) begin
                    r_d.st  = ST_RX_ADDR;
                    r_d.cnt = '0;
                end
            end
            ST_RX_ADDR: begin
                if (scl_rise) begin
                    r_d.sh  = sh_nx;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                        if (hit) begin
                            r_d.st      = ST_ACK;
                            r_d.ack_drv = 1'b0;
                            r_d.flag    = 1'b1;
                        end else begin
                            r_d.st  = ST_DONE;
                            r_d.req = 1'b0;
                        end
                    end
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    if (!r_q.ack_drv) begin
                        r_d.ack_drv = 1'b1;
                    end else begin
                        r_d.ack_drv = 1'b0;
                        r_d.st      = ST_HOLD_WAKE;
                    end
                end
            end
            ST_HOLD_WAKE: begin
                if (flag_clr) begin
                    r_d.st = ST_RELEASE;
                end
            end
            ST_RELEASE: r_d.st = ST_DONE;
            ST_DONE: ;
            default: r_d.st = ST_IDLE;
        endcase
        if (start) begin
            r_d.st      = ST_WAIT_CLK;
            r_d.req     = 1'b1;
            r_d.cnt     = '0;
            r_d.ack_drv = 1'b0;
        end else if (stop) begin
            r_d.st      = ST_IDLE;
            r_d.req     = 1'b0;
            r_d.ack_drv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, sh: '0, cnt: '0, ack_drv: 1'b0, req: 1'b0, flag: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_oe  = (r_q.st == ST_WAIT_CLK) || (r_q.st == ST_HOLD_WAKE);
    assign sda_oe  = (r_q.st == ST_ACK) && r_q.ack_drv;
    assign clk_req = r_q.req;
    assign wake_o  = r_q.flag;
endmodule

// File: rtl/i2c_wake_ctrl_chk.sv
module i2c_wake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic clk_req,
    input logic clk_rdy,
    input logic wake_o,
    input logic flag_clr
);
    AST_HOLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> clk_req);                                   // R3
    AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_oe && sda_oe));                                  // R5
    AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> clk_req);                                   // R7
    AST_WAKE_RISE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> (!scl_oe && clk_req));               // R5
    AST_RELEASE_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && wake_o && scl_oe && clk_rdy) |=> !scl_oe); // R6
endmodule

bind i2c_wake_ctrl i2c_wake_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .clk_req  (clk_req),
    .clk_rdy  (clk_rdy),
    .wake_o   (wake_o),
    .flag_clr (flag_clr)
);

// File: tb/test_i2c_wake_ctrl.sv
module test_i2c_wake_ctrl;
    localparam int T = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_scl_low = 1'b0;
    logic       tb_sda_low = 1'b0;
    logic       clk_rdy = 1'b0;
    logic [6:0] own_addr = 7'h5A;
    logic       gc_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       scl_oe, sda_oe, clk_req, wake_o;
    logic       scl_line, sda_line;
    int         rdy_dly = 40;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = !(tb_scl_low || scl_oe);
    assign sda_line = !(tb_sda_low || sda_oe);

    i2c_wake_ctrl i_i2c_wake_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_line),
        .sda_i    (sda_line),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .clk_req  (clk_req),
        .clk_rdy  (clk_rdy),
        .own_addr (own_addr),
        .gc_en    (gc_en),
        .wake_o   (wake_o),
        .flag_clr (flag_clr)
    );

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (clk_req) begin
                cnt++;
                clk_rdy = (cnt >= rdy_dly);
            end else begin
                cnt = 0;
                clk_rdy = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_release;
        int guard = 0;
        tb_scl_low = 1'b0;
        @(negedge clk);
        while (!scl_line && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic bus_start;
        tb_sda_low = 1'b0;
        tb_scl_low = 1'b0;
        wt(T);
        tb_sda_low = 1'b1;
        wt(T);
        tb_scl_low = 1'b1;
        wt(T);
    endtask

    task automatic bus_stop;
        tb_sda_low = 1'b1;
        wt(T);
        scl_release();
        wt(T);
        tb_sda_low = 1'b0;
        wt(T + 10);
    endtask

    task automatic bus_bit(input bit v, output bit line_seen);
        tb_sda_low = !v;
        wt(T);
        scl_release();
        wt(T);
        line_seen = sda_line;
        tb_scl_low = 1'b1;
        wt(T);
    endtask

    task automatic xfer(input logic [6:0] a, input bit rw);
        bit exp_hit;
        bit seen;
        logic [7:0] byt;
        exp_hit = (a == 7'd0) ? gc_en : (a == own_addr);
        byt = {a, rw};
        bus_start();
        // R2: request and stretch right after START; R3: clock not yet ready
        chk(clk_req == 1'b1, "R2 clk_req after START", clk_req, 1);
        chk(scl_oe == 1'b1 && clk_rdy == 1'b0, "R3 SCL held before ready", scl_oe, 1);
        for (int i = 7; i >= 0; i--) begin
            bus_bit(byt[i], seen);
        end
        bus_bit(1'b1, seen);
        // R4 R5 R7 R8: acknowledge decided by the address
        chk(seen == !exp_hit, "R4 R8 ack level", seen, !exp_hit);
        wt(T);
        if (exp_hit) begin
            wt(30);
            chk(scl_oe == 1'b1 && scl_line == 1'b0, "R6 stretch during wake", scl_oe, 1);
            chk(wake_o == 1'b1, "R5 wake on match", wake_o, 1);
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
            wt(3);
            chk(scl_oe == 1'b0 && wake_o == 1'b0, "R6 release on clear", {scl_oe, wake_o}, 0);
            chk(clk_req == 1'b1, "R6 req kept until STOP", clk_req, 1);
        end else begin
            chk(wake_o == 1'b0 && sda_oe == 1'b0, "R7 no wake on mismatch", {wake_o, sda_oe}, 0);
            chk(clk_req == 1'b0, "R7 req withdrawn", clk_req, 0);
        end
        tb_scl_low = 1'b1;
        bus_stop();
        chk(clk_req == 1'b0 && scl_oe == 1'b0, "R9 idle after STOP", {clk_req, scl_oe}, 0);
    endtask

    initial begin
        wt(200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wt(3);
        // R1: outputs inactive in reset and just after
        chk({scl_oe, sda_oe, clk_req, wake_o} == 4'b0, "R1 reset outputs", {scl_oe, sda_oe, clk_req, wake_o}, 0);
        rst_n = 1'b1;
        wt(5);
        chk({scl_oe, sda_oe, clk_req, wake_o} == 4'b0, "R1 after reset", {scl_oe, sda_oe, clk_req, wake_o}, 0);

        // R10: single-cycle SDA glitch while idle
        tb_sda_low = 1'b1;
        @(negedge clk);
        tb_sda_low = 1'b0;
        wt(20);
        chk(clk_req == 1'b0, "R10 glitch ignored", clk_req, 0);

        // R3: long clock startup keeps SCL low
        rdy_dly = 300;
        bus_start();
        wt(150);
        chk(scl_oe == 1'b1 && scl_line == 1'b0, "R3 long stretch", scl_oe, 1);
        tb_scl_low = 1'b1;
        wt(200);
        chk(scl_oe == 1'b0, "R3 released after ready", scl_oe, 0);
        bus_stop();
        chk(clk_req == 1'b0, "R9 STOP from RX", clk_req, 0);
        rdy_dly = 40;

        // R4 R7 R8: every address against a fixed own address
        own_addr = 7'h5A;
        gc_en = 1'b0;
        for (int a = 0; a < 128; a++) begin
            xfer(7'(a), a[0]);
        end
        // R8: general call enabled
        gc_en = 1'b1;
        xfer(7'd0, 1'b0);
        gc_en = 1'b0;
        // R5 R6: sweep of own addresses
        for (int o = 1; o < 128; o += 6) begin
            own_addr = 7'(o);
            xfer(7'(o), o[1]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule